// File: doc/BRIEF.md
# Width-Keeping Quarter-Rate Prescaler

This block lowers the rate of a square-wave signal by a power of two (four by default) without discarding how long each input pulse stays high. A chain of rising-edge toggle stages produces a slow square wave whose high time is fixed by the input period and says nothing about the input pulse width. A single falling-edge stage copies that slow wave on each falling input edge, so its copy lags the divider by exactly the input high time P. Gating the divider complement with the copy yields two slow pulse trains: one whose high time equals P, and one whose high time is the divider half-period minus P. With four-way division that second width is P' = 2T - P, where T is the input period.

A measurement unit downstream sees one signal, `meas_out`. When `range_hi` is low, the raw input is passed through for slow signals. When `range_hi` is high, the divided, width-carrying train is passed through for fast ones. A build parameter picks which of the two gated trains feeds the divided path. The wide variant keeps short pulses measurable. Both gated trains are also brought out. All stages are clocked by the input signal itself, and an asynchronous active-low reset clears every stage so that the trains start in a known phase.

Top module: `quad_width_prescaler`

## Requirements
- R1: While `rst_n` is low, every stage is cleared regardless of edges on `sig_in`: `gated_p` reads 0 and `gated_pp` reads 1.
- R2: Counting rising edges of `sig_in` from reset release as 1, 2, 3 and so on, `gated_p` goes high only at rising edges numbered 3, 7, 11, ... (number mod 4 equal to 3, default of two divider stages).
- R3: `gated_p` returns low at the first falling edge of `sig_in` after it rose, so its high time equals the input high time, and it is never high while `sig_in` is low.
- R4: `gated_pp` goes high at the falling edge that follows a rising edge numbered 3 mod 4, and goes low at the rising edge numbered 1 mod 4. It also reads high from reset release until the first rising edge.
- R5: For a steady input of period T and high time P, each high interval of `gated_pp` lasts 2T - P.
- R6: With `range_hi` = 0, `meas_out` equals `sig_in` at all times.
- R7: With `range_hi` = 1, `meas_out` equals `gated_p` when parameter `PASS_WIDE` = 0 (the default), or `gated_pp` when `PASS_WIDE` = 1.
- R8: `range_hi` has no effect on `gated_p` or `gated_pp`. A change of `range_hi` reaches `meas_out` at once, without waiting for an edge of `sig_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | 1 | Square-wave signal to be prescaled; it also clocks every stage |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| range_hi | input | 1 | 0 selects the raw input, 1 selects the divided width-carrying train |
| meas_out | output | 1 | Selected measurement signal |
| gated_p | output | 1 | Divided train whose high time equals the input high time |
| gated_pp | output | 1 | Divided train whose high time is the divider half-period minus the input high time |

## Verification
The range selection and the divider can act at the same instant: `range_hi` is flipped in the very cycle that `sig_in` rises or falls. Sometimes that edge is the one that starts or ends a gated pulse. The bench changes both in one step. After the step it compares `meas_out` with the new selection applied to a reference model of edge counts and follower state. It also confirms that the gated trains follow the edge alone. A static toggle of `range_hi` with no edge confirms that the select path is combinational.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

  // Active edge of a storage cell.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Next state of a set/reset/toggle cell: 10 sets, 01 clears,
  // 11 toggles, 00 holds.
  function automatic logic jk_next(input logic q, input logic j, input logic k);
    logic nxt;
    unique case ({j, k})
      2'b10:   nxt = 1'b1;
      2'b01:   nxt = 1'b0;
      2'b11:   nxt = ~q;
      default: nxt = q;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/qwp_jk_cell.sv
module qwp_jk_cell
  import qwp_pkg::*;
#(
  parameter edge_sel_e EDGE = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);

  logic q_r;

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= 1'b0;
        else         q_r <= jk_next(q_r, j_i, k_i);
      end
    end else begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= 1'b0;
        else         q_r <= jk_next(q_r, j_i, k_i);
      end
    end
  endgenerate

  assign q_o = q_r;

endmodule

// File: rtl/qwp_ripple_div.sv
module qwp_ripple_div
  import qwp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic sig_in,
  input  logic rst_n,
  output logic div_q,
  output logic div_qn
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] st_q;

  // Each stage toggles on the rising edge of the one before it;
  // the first stage is clocked by the input signal.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_clk;
      if (g == 0) begin : g_head
        assign stage_clk = sig_in;
      end else begin : g_tail
        assign stage_clk = st_q[g-1];
      end
      qwp_jk_cell #(.EDGE(EDGE_RISE)) u_cell (
        .clk_i  (stage_clk),
        .rst_ni (rst_n),
        .j_i    (1'b1),
        .k_i    (1'b1),
        .q_o    (st_q[g])
      );
    end
  endgenerate

  assign div_q  = st_q[MSB];
  assign div_qn = ~st_q[MSB];

endmodule

// File: rtl/qwp_fall_follow.sv
module qwp_fall_follow
  import qwp_pkg::*;
(
  input  logic sig_in,
  input  logic rst_n,
  input  logic div_q,
  input  logic div_qn,
  output logic foll_q
);

  // Set from the divider true output, cleared from its complement:
  // at every falling input edge the cell copies the divider state.
  qwp_jk_cell #(.EDGE(EDGE_FALL)) u_cell (
    .clk_i  (sig_in),
    .rst_ni (rst_n),
    .j_i    (div_q),
    .k_i    (div_qn),
    .q_o    (foll_q)
  );

endmodule

// File: rtl/qwp_gate_sel.sv
module qwp_gate_sel #(
  parameter bit PASS_WIDE = 1'b0
) (
  input  logic sig_in,
  input  logic range_hi,
  input  logic div_qn,
  input  logic foll_q,
  output logic gated_p,
  output logic gated_pp,
  output logic meas_out
);

  logic div_path;

  assign gated_p  = div_qn & foll_q;
  assign gated_pp = div_qn & ~foll_q;

  generate
    if (PASS_WIDE) begin : g_wide
      assign div_path = gated_pp;
    end else begin : g_narrow
      assign div_path = gated_p;
    end
  endgenerate

  // Two gated paths merged by an OR.
  assign meas_out = (sig_in & ~range_hi) | (div_path & range_hi);

endmodule

// File: rtl/quad_width_prescaler.sv
module quad_width_prescaler #(
  parameter int DIV_STAGES = 2,
  parameter bit PASS_WIDE  = 1'b0
) (
  input  logic sig_in,
  input  logic rst_n,
  input  logic range_hi,
  output logic meas_out,
  output logic gated_p,
  output logic gated_pp
);

  logic div_q;
  logic div_qn;
  logic foll_q;

  qwp_ripple_div #(.STAGES(DIV_STAGES)) u_div (
    .sig_in (sig_in),
    .rst_n  (rst_n),
    .div_q  (div_q),
    .div_qn (div_qn)
  );

  qwp_fall_follow u_follow (
    .sig_in (sig_in),
    .rst_n  (rst_n),
    .div_q  (div_q),
    .div_qn (div_qn),
    .foll_q (foll_q)
  );

  qwp_gate_sel #(.PASS_WIDE(PASS_WIDE)) u_sel (
    .sig_in   (sig_in),
    .range_hi (range_hi),
    .div_qn   (div_qn),
    .foll_q   (foll_q),
    .gated_p  (gated_p),
    .gated_pp (gated_pp),
    .meas_out (meas_out)
  );

endmodule

// File: rtl/qwp_checker.sv
module qwp_checker #(
  parameter int STAGES    = 2,
  parameter bit PASS_WIDE = 1'b0
) (
  input logic sig_in,
  input logic rst_n,
  input logic range_hi,
  input logic meas_out,
  input logic gated_p,
  input logic gated_pp
);

  localparam int MOD = 1 << STAGES;
  localparam logic [STAGES-1:0] PH = STAGES'((MOD / 2 + 1) % MOD);

  // Independent count of rising input edges since reset release.
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] neg_cnt;

  always_ff @(posedge sig_in or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign neg_cnt = '0 - cnt;

  p_rise_phase_r2: assert property (@(negedge sig_in) disable iff (!rst_n)
    gated_p == (cnt == PH));

  p_low_idle_r3: assert property (@(posedge sig_in) disable iff (!rst_n)
    !gated_p);

  p_wide_window_r4: assert property (@(posedge sig_in) disable iff (!rst_n)
    gated_pp == !neg_cnt[STAGES-1]);

  p_pass_high_r6: assert property (@(negedge sig_in) disable iff (!rst_n)
    !range_hi |-> meas_out);

  p_pass_low_r6: assert property (@(posedge sig_in) disable iff (!rst_n)
    !range_hi |-> !meas_out);

  generate
    if (PASS_WIDE) begin : g_wide
      p_divided_r7: assert property (@(posedge sig_in) disable iff (!rst_n)
        range_hi |-> meas_out == !neg_cnt[STAGES-1]);
    end else begin : g_narrow
      p_divided_r7: assert property (@(negedge sig_in) disable iff (!rst_n)
        range_hi |-> meas_out == (cnt == PH));
    end
  endgenerate

endmodule

bind quad_width_prescaler qwp_checker #(
  .STAGES    (DIV_STAGES),
  .PASS_WIDE (PASS_WIDE)
) u_chk (
  .sig_in   (sig_in),
  .rst_n    (rst_n),
  .range_hi (range_hi),
  .meas_out (meas_out),
  .gated_p  (gated_p),
  .gated_pp (gated_pp)
);

// File: tb/quad_width_prescaler_test.sv
`timescale 1ns/1ps
module quad_width_prescaler_test;

  logic clk = 1'b0;
  logic sig_in = 1'b0;
  logic rst_n = 1'b0;
  logic range_hi = 1'b0;
  logic meas_out, gated_p, gated_pp;

  int errors = 0;
  int checks = 0;
  int n = 0;       // rising edges since reset release
  bit f = 1'b0;    // model of the falling-edge copy
  int gp_run = 0, gp_len = 0, pp_run = 0, pp_len = 0;

  always #2 clk = ~clk;

  quad_width_prescaler uut (
    .sig_in   (sig_in),
    .rst_n    (rst_n),
    .range_hi (range_hi),
    .meas_out (meas_out),
    .gated_p  (gated_p),
    .gated_pp (gated_pp)
  );

  function automatic bit exp_div(input int cnt);
    return (cnt % 4 == 1) || (cnt % 4 == 2);
  endfunction

  function automatic bit exp_gp();
    return !exp_div(n) && f;
  endfunction

  function automatic bit exp_gpp();
    return !exp_div(n) && !f;
  endfunction

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    check_val("R2/R3 gated_p", gated_p, exp_gp());
    check_val("R4 gated_pp", gated_pp, exp_gpp());
    if (range_hi) check_val("R7 meas_out divided", meas_out, exp_gp());
    else          check_val("R6 meas_out direct", meas_out, sig_in);
  endtask

  task automatic sample_cycle();
    @(negedge clk);
    if (gated_p) gp_run++;
    else if (gp_run > 0) begin gp_len = gp_run; gp_run = 0; end
    if (gated_pp) pp_run++;
    else if (pp_run > 0) begin pp_len = pp_run; pp_run = 0; end
  endtask

  task automatic drive_edge(input bit lvl, input int hold, input bit chg, input bit rng);
    @(posedge clk);
    sig_in = lvl;
    if (chg) range_hi = rng;
    if (lvl) n++;
    else     f = exp_div(n);
    repeat (hold) sample_cycle();
    check_outs();
  endtask

  task automatic train(input int hi, input int lo, input int periods);
    for (int i = 0; i < periods; i++) begin
      drive_edge(1'b1, hi, 1'b0, 1'b0);
      drive_edge(1'b0, lo, 1'b0, 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);

    // R1: reset state, edges ignored while held.
    #5;
    check_val("R1 gated_p in reset", gated_p, 0);
    check_val("R1 gated_pp in reset", gated_pp, 1);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); sig_in = 1'b1; @(negedge clk);
      @(posedge clk); sig_in = 1'b0; @(negedge clk);
    end
    check_val("R1 gated_p after edges in reset", gated_p, 0);
    check_val("R1 gated_pp after edges in reset", gated_pp, 1);
    @(posedge clk); rst_n = 1'b1; n = 0; f = 1'b0;
    @(negedge clk);
    check_outs();

    // R3/R5: steady trains through the divided path.
    range_hi = 1'b1;
    train(3, 5, 10);
    check_val("R3 gated_p width 3", gp_len, 3);
    check_val("R5 gated_pp width 2*8-3", pp_len, 13);
    train(6, 2, 10);
    check_val("R3 gated_p width 6", gp_len, 6);
    check_val("R5 gated_pp width 2*8-6", pp_len, 10);
    train(1, 1, 10);
    check_val("R3 gated_p width 1", gp_len, 1);
    check_val("R5 gated_pp width 2*2-1", pp_len, 3);

    // R6: direct path.
    range_hi = 1'b0;
    train(2, 3, 4);

    // R8: select flips with no edge, in both input levels.
    for (int i = 0; i < 8; i++) begin
      bit gp0, gpp0;
      drive_edge(1'b1, 1 + i % 3, 1'b0, 1'b0);
      gp0 = gated_p; gpp0 = gated_pp;
      @(posedge clk); range_hi = ~range_hi; #1;
      check_val("R8 gated_p unchanged by select", gated_p, gp0);
      check_val("R8 gated_pp unchanged by select", gated_pp, gpp0);
      check_val("R8 meas_out follows select at once", meas_out,
                range_hi ? exp_gp() : sig_in);
      drive_edge(1'b0, 2, 1'b0, 1'b0);
    end

    // Random widths, select flipped together with edges.
    for (int i = 0; i < 300; i++) begin
      bit chg = ($urandom_range(3, 0) == 0);
      drive_edge(1'b1, $urandom_range(6, 1), chg, 1'($urandom_range(1, 0)));
      chg = ($urandom_range(3, 0) == 0);
      drive_edge(1'b0, $urandom_range(6, 1), chg, 1'($urandom_range(1, 0)));
    end

    // R1: asynchronous clear in mid run, while input is high.
    drive_edge(1'b1, 2, 1'b0, 1'b0);
    drive_edge(1'b0, 2, 1'b0, 1'b0);
    drive_edge(1'b1, 2, 1'b0, 1'b0);
    @(posedge clk); rst_n = 1'b0; #1;
    check_val("R1 gated_p on async clear", gated_p, 0);
    check_val("R1 gated_pp on async clear", gated_pp, 1);
    @(posedge clk); sig_in = 1'b0; #1;
    @(posedge clk); rst_n = 1'b1; n = 0; f = 1'b0;
    range_hi = 1'b1;
    @(negedge clk);
    check_outs();
    train(2, 2, 6);

    finish_run();
  end

endmodule